// File: doc/BRIEF.md
# Fixed Digit Sequence Generator

This block plays a fixed run of twelve decimal digits, 3,2,3,1,3,5,3,4,3,3,5,5. It puts out one digit per clock as a 4-bit value. The pattern is built into the hardware when the design is elaborated. The run can be started again at any time with a synchronous restart input. The block can be used as a test-pattern source, or as a known stimulus for a downstream stage that decodes digits.

A mode input chooses between two playback behaviours, and it is sampled only on a restart. In cyclic mode the pattern wraps around with no idle cycle and repeats forever. In one-shot mode the pattern plays once. After that the output holds a constant filler digit and a done flag is raised, and both stay that way until the next restart. A valid flag marks every cycle in which a pattern digit is on the output.

Top module: `digit_pattern_gen`

## Requirements
- R1: After the asynchronous reset `rst_n` is low, and until the first restart, `digit` is 0 while `digit_valid` and `done` are both 0, whatever the value of `cyclic_sel`.
- R2: On a clock edge where `restart` is 1, the outputs become `digit`=0, `digit_valid`=0 and `done`=0. On the first following edge where `restart` is 0, `digit` becomes 3 and `digit_valid` becomes 1.
- R3: After a restart, the digits on consecutive clocks are 3,2,3,1,3,5,3,4,3,3,5,5, each coded as an unsigned 4-bit binary value. `digit_valid` is 1 for every one of these digits.
- R4: When `cyclic_sel`=1 is sampled on the restart edge, the digit 3 follows the twelfth digit on the very next clock, and the run repeats without end. `done` stays 0 throughout.
- R5: When `cyclic_sel`=0 is sampled on the restart edge, every clock after the twelfth digit gives `digit`=1, `digit_valid`=0 and `done`=1, until the next restart.
- R6: `cyclic_sel` is ignored except on an edge where `restart` is 1. A change of its value between restarts has no effect on `digit`, `digit_valid` or `done`.
- R7: A restart in the middle of a run abandons that run. The next digit is again the first digit of the pattern.
- R8: `digit_valid` and `done` are never 1 at the same time. The internal position counter never goes beyond 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the idle state |
| restart | input | 1 | Synchronous start or restart of the pattern |
| cyclic_sel | input | 1 | Playback mode sampled at restart: 1 cyclic, 0 one-shot |
| digit | output | 4 | Current digit |
| digit_valid | output | 1 | High when `digit` carries a pattern digit |
| done | output | 1 | High while a one-shot run holds the filler digit |

## Verification
Some properties are checked by the assertions on every cycle. These are: the cleared outputs after a restart edge, the first digit being 3, the filler and done state staying put once entered, done never rising under a latched cyclic mode, valid and done never overlapping, and the counter bound. Other behaviours need whole scenarios from the bench. These are the full twelve-digit order, the seamless wrap from 5 back to 3, immunity to mode changes between restarts, the idle output before the first restart, and a restart cutting a run short.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

  localparam int DIG_W      = 4;
  localparam int SEQ_LEN    = 12;
  localparam int FILL_DIGIT = 1;

  // Pattern digit at playback position idx (0 plays first).
  function automatic logic [3:0] seq_digit(input int idx);
    logic [3:0] d;
    case (idx)
      0, 2, 4, 6, 8, 9: d = 4'd3;
      1:                d = 4'd2;
      3:                d = 4'd1;
      5, 10, 11:        d = 4'd5;
      7:                d = 4'd4;
      default:          d = 4'd0;
    endcase
    return d;
  endfunction

  // Position after emitting one digit: wraps in cyclic mode, parks at len otherwise.
  function automatic int seq_advance(input int pos, input logic cyclic, input int len);
    int nxt;
    if (pos == len - 1) nxt = cyclic ? 0 : len;
    else                nxt = pos + 1;
    return nxt;
  endfunction

endpackage

// File: rtl/seqgen_ctrl.sv
module seqgen_ctrl #(
  parameter int SEQ_LEN = seqgen_pkg::SEQ_LEN,
  parameter int CNT_W   = $clog2(SEQ_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cyclic_sel,
  output logic             load,
  output logic             step,
  output logic             hold,
  output logic [CNT_W-1:0] pos_q,
  output logic             mode_q
);
  import seqgen_pkg::*;

  localparam logic [CNT_W-1:0] END_POS = CNT_W'(SEQ_LEN);

  logic armed_q;
  logic [CNT_W-1:0] pos_nxt;

  assign load = restart;
  assign step = armed_q && !restart && (pos_q < END_POS);
  assign hold = armed_q && !restart && (pos_q == END_POS);

  assign pos_nxt = CNT_W'(seq_advance(int'(pos_q), mode_q, SEQ_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pos_q   <= '0;
      mode_q  <= 1'b0;
    end else if (restart) begin
      armed_q <= 1'b1;
      pos_q   <= '0;
      mode_q  <= cyclic_sel;
    end else if (step) begin
      pos_q   <= pos_nxt;
    end
  end

endmodule

// File: rtl/seqgen_store.sv
module seqgen_store #(
  parameter int DIG_W   = seqgen_pkg::DIG_W,
  parameter int SEQ_LEN = seqgen_pkg::SEQ_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [DIG_W-1:0] head
);
  import seqgen_pkg::*;

  localparam int PAT_W = DIG_W * SEQ_LEN;

  logic [PAT_W-1:0] init_pat;
  logic [PAT_W-1:0] pat_q;

  // Position 0 sits in the lowest slice, so the pattern reads reversed from the top.
  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_pat
    assign init_pat[i*DIG_W +: DIG_W] = DIG_W'(seq_digit(i));
  end

  assign head = pat_q[DIG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pat_q <= init_pat;
    else if (load)  pat_q <= init_pat;
    else if (step)  pat_q <= {pat_q[DIG_W-1:0], pat_q[PAT_W-1:DIG_W]};
  end

endmodule

// File: rtl/seqgen_out.sv
module seqgen_out #(
  parameter int DIG_W      = seqgen_pkg::DIG_W,
  parameter int FILL_DIGIT = seqgen_pkg::FILL_DIGIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             hold,
  input  logic [DIG_W-1:0] head,
  output logic [DIG_W-1:0] digit,
  output logic             digit_valid,
  output logic             done
);

  localparam logic [DIG_W-1:0] FILL = DIG_W'(FILL_DIGIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit       <= '0;
      digit_valid <= 1'b0;
      done        <= 1'b0;
    end else if (load) begin
      digit       <= '0;
      digit_valid <= 1'b0;
      done        <= 1'b0;
    end else if (step) begin
      digit       <= head;
      digit_valid <= 1'b1;
      done        <= 1'b0;
    end else if (hold) begin
      digit       <= FILL;
      digit_valid <= 1'b0;
      done        <= 1'b1;
    end
  end

endmodule

// File: rtl/digit_pattern_gen.sv
module digit_pattern_gen #(
  parameter int DIG_W      = seqgen_pkg::DIG_W,
  parameter int SEQ_LEN    = seqgen_pkg::SEQ_LEN,
  parameter int FILL_DIGIT = seqgen_pkg::FILL_DIGIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cyclic_sel,
  output logic [DIG_W-1:0] digit,
  output logic             digit_valid,
  output logic             done
);

  localparam int CNT_W = $clog2(SEQ_LEN + 1);

  // Named internal events, also observed by the bound checker.
  logic             ev_load;
  logic             ev_step;
  logic             ev_hold;
  logic [CNT_W-1:0] pos_q;
  logic             mode_q;
  logic [DIG_W-1:0] head;

  seqgen_ctrl #(.SEQ_LEN(SEQ_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cyclic_sel(cyclic_sel),
    .load(ev_load), .step(ev_step), .hold(ev_hold), .pos_q(pos_q), .mode_q(mode_q)
  );

  seqgen_store #(.DIG_W(DIG_W), .SEQ_LEN(SEQ_LEN)) u_store (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .step(ev_step), .head(head)
  );

  seqgen_out #(.DIG_W(DIG_W), .FILL_DIGIT(FILL_DIGIT)) u_out (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .step(ev_step), .hold(ev_hold),
    .head(head), .digit(digit), .digit_valid(digit_valid), .done(done)
  );

endmodule

// File: rtl/seqgen_checker.sv
module seqgen_checker #(
  parameter int DIG_W      = 4,
  parameter int SEQ_LEN    = 12,
  parameter int FILL_DIGIT = 1,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic [DIG_W-1:0] digit,
  input logic             digit_valid,
  input logic             done,
  input logic             ev_step,
  input logic [CNT_W-1:0] pos_q,
  input logic             mode_q
);

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (digit == '0 && !digit_valid && !done)); // R2

  AST_FIRST_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (restart ##1 !restart) |=> (digit == DIG_W'(3) && digit_valid)); // R2

  AST_STEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> digit_valid); // R3

  AST_CYCLIC_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !done); // R4

  AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> (done && !digit_valid && digit == DIG_W'(FILL_DIGIT))); // R5

  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(digit_valid && done)); // R8

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= CNT_W'(SEQ_LEN)); // R8

endmodule

bind digit_pattern_gen seqgen_checker #(
  .DIG_W(DIG_W), .SEQ_LEN(SEQ_LEN), .FILL_DIGIT(FILL_DIGIT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .digit(digit),
  .digit_valid(digit_valid), .done(done), .ev_step(ev_step),
  .pos_q(pos_q), .mode_q(mode_q)
);

// File: tb/sim_digit_pattern_gen.sv
`timescale 1ns/1ps
module sim_digit_pattern_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       cyclic_sel = 1'b0;
  logic [3:0] digit;
  logic       digit_valid;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  digit_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cyclic_sel(cyclic_sel),
    .digit(digit), .digit_valid(digit_valid), .done(done)
  );

  // Expected pattern, written independently of the design.
  localparam logic [3:0] EXP_SEQ [12] = '{4'd3, 4'd2, 4'd3, 4'd1, 4'd3, 4'd5,
                                         4'd3, 4'd4, 4'd3, 4'd3, 4'd5, 4'd5};

  // Vector byte: {restart, cyclic_sel, digit[3:0], valid, done}
  localparam int NVEC = 36;
  localparam logic [7:0] VEC [NVEC] = '{
    8'h80,
    8'h0E, 8'h0A, 8'h0E, 8'h06, 8'h0E, 8'h16, 8'h0E, 8'h12, 8'h0E, 8'h0E, 8'h16, 8'h16,
    8'h45, 8'h45,
    8'hC0,
    8'h0E, 8'h0A, 8'h0E, 8'h06, 8'h0E, 8'h16, 8'h0E, 8'h12, 8'h0E, 8'h0E, 8'h16, 8'h16,
    8'h0E, 8'h0A,
    8'h80,
    8'h0E, 8'h0A, 8'h0E,
    8'h80,
    8'h0E
  };

  function automatic string vec_tag(input int i);
    if (i == 0 || i == 15 || i == 30 || i == 34) return "R2";
    if (i >= 1 && i <= 12)  return "R3";
    if (i == 13 || i == 14) return "R5/R6";
    if (i >= 16 && i <= 27) return "R3";
    if (i == 28 || i == 29) return "R4/R6";
    if (i == 35)            return "R7";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [3:0] ed, input logic ev, input logic edn);
    checks++;
    if (digit !== ed || digit_valid !== ev || done !== edn) begin
      fails++;
      $display("FAIL %s: got digit=%0d valid=%0b done=%0b, expected digit=%0d valid=%0b done=%0b",
               tag, digit, digit_valid, done, ed, ev, edn);
    end
  endtask

  task automatic tick(input logic r, input logic c);
    restart    = r;
    cyclic_sel = c;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    // R1: idle output under reset and before any restart
    #5;
    check("R1 in reset", 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < 3; k++) begin
      tick(1'b0, k[0]);
      check("R1 before first restart", 4'd0, 1'b0, 1'b0);
    end

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      tick(VEC[i][7], VEC[i][6]);
      check(vec_tag(i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R4: long cyclic run, several wraps, mode input toggled (R6)
    tick(1'b1, 1'b1);
    for (int k = 0; k < 40; k++) begin
      tick(1'b0, k[1]);
      check("R4 cyclic wrap", EXP_SEQ[k % 12], 1'b1, 1'b0);
    end

    // R5: one-shot holds filler for a long time; R8 exclusivity
    tick(1'b1, 1'b0);
    for (int k = 0; k < 30; k++) begin
      tick(1'b0, k[2]);
      if (k < 12) check("R3 one-shot digit", EXP_SEQ[k], 1'b1, 1'b0);
      else        check("R5 filler hold", 4'd1, 1'b0, 1'b1);
      checks++;
      if (digit_valid && done) begin
        fails++;
        $display("FAIL R8: got valid=1 done=1, expected not both");
      end
    end

    // R7: restart at last digit of a one-shot run
    tick(1'b1, 1'b0);
    for (int k = 0; k < 11; k++) tick(1'b0, 1'b0);
    check("R7 before restart", 4'd5, 1'b1, 1'b0);
    tick(1'b1, 1'b0);
    check("R7 restart clears", 4'd0, 1'b0, 1'b0);
    tick(1'b0, 1'b0);
    check("R7 first digit again", 4'd3, 1'b1, 1'b0);

    // R1: asynchronous reset mid-run returns to idle until restart
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    tick(1'b0, 1'b1);
    check("R1 idle after reset", 4'd0, 1'b0, 1'b0);

    finish_run();
  end

endmodule